// File: doc/BRIEF.md
# Compartment Address Decoder with Register Window

This block sits on a 32-bit processor-side bus and decides whether each access belongs to it. It does not compare the address against a base and a mask. It cuts a middle slice out of the address, reads that slice as a compartment number, and claims the access only when the number falls inside an inclusive window of compartments. Two parameters set how many low address bits and how many high address bits are left out of the decode. Two more parameters give the first and the last compartment the block owns.

When an access is claimed, the block raises a select and passes on qualified read and write strobes. It also produces an offset that is relative to the start of its own region. A small bank of registers sits behind the decoder so that a write followed by a read shows the decode working end to end.

Read data comes back one clock after the read strobe, marked by a one-cycle valid. At every other time the read data is zero, so several such blocks can share a bus whose read data is combined with OR.

Top module: `cmpt_decoder`

## Requirements
- R1: The compartment number is the address slice `bus_addr[LO_SKIP+NDEC-1:LO_SKIP]`, with `NDEC = (31 - HI_SKIP) - LO_SKIP`. With the defaults (LO_SKIP=10, HI_SKIP=16) this is `bus_addr[14:10]`, and bits 31..15 never change the decode.
- R2: `sel` is high in the same cycle as the address when FIRST_C <= compartment <= LAST_C, both ends included, and low otherwise. The defaults are 2 and 3, so the owned addresses are 0x800 to 0xFFF within each 32K alias.
- R3: The low LO_SKIP address bits never change `sel`, so each compartment spans 2^LO_SKIP addresses (1024 by default).
- R4: `loc_rd` and `loc_wr` follow `bus_rd` and `bus_wr` only while `sel` is high. A write to an address outside the window leaves every register unchanged.
- R5: `loc_off` equals the address minus FIRST_C*2^LO_SKIP, truncated to LO_SKIP+clog2(LAST_C-FIRST_C+1) bits (11 bits by default). For example, 0xC05 gives 0x405.
- R6: A read the block claims returns data on `rdata` in the cycle after the strobe, with `rvalid` high for exactly that one cycle. A read outside the window produces no `rvalid`.
- R7: `rdata` is zero in every cycle where `rvalid` is low.
- R8: Register index = `loc_off[2:0]` (8 registers by default). The registers repeat every 8 addresses across the region, and a read returns the value last written to that index.
- R9: Reset (`rst_n` low) clears every register to zero and holds `rvalid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Access address |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| sel | output | 1 | Address lies inside the owned compartment window |
| loc_rd | output | 1 | Read strobe qualified by select |
| loc_wr | output | 1 | Write strobe qualified by select |
| loc_off | output | OFFW | Offset from the start of the owned region |
| rdata | output | 32 | Read data, zero unless valid |
| rvalid | output | 1 | One-cycle read-data valid |

## Verification
The bench probes the addresses on both sides of each window edge: 0x7FF and 0x800, and 0xFFF and 0x1000. A decoder that used an exclusive bound, or a slice shifted by one bit, would lose or gain one whole compartment there.

It sets the high address bits that are excluded from the decode. A decoder that compared the full address would drop those accesses.

It writes outside the window and then reads inside it. A missing qualification on the write strobe would corrupt a register.

It checks that `rdata` is zero both before and after the valid cycle, and after a read outside the window. A block that leaves stale data on the bus would break the OR-combined read path.

// File: rtl/cmpt_decoder.sv
module cmpt_decoder #(
  parameter int LO_SKIP = 10,
  parameter int HI_SKIP = 16,
  parameter int FIRST_C = 2,
  parameter int LAST_C  = 3,
  parameter int NREG    = 8,
  parameter int DW      = 32,
  localparam int NDEC   = (31 - HI_SKIP) - LO_SKIP,
  localparam int NCOMP  = LAST_C - FIRST_C + 1,
  localparam int CW     = $clog2(NCOMP),
  localparam int OFFW   = LO_SKIP + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_rd,
  input  logic            bus_wr,
  output logic            sel,
  output logic            loc_rd,
  output logic            loc_wr,
  output logic [OFFW-1:0] loc_off,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  localparam int RIW = $clog2(NREG);
  localparam logic [NDEC-1:0] FIRST_V = NDEC'(FIRST_C);
  localparam logic [NDEC-1:0] LAST_V  = NDEC'(LAST_C);

  if (LAST_C < FIRST_C || HI_SKIP + LO_SKIP > 31 || NDEC < 1 ||
      LAST_C >= (1 << NDEC) || OFFW < RIW || CW > NDEC) begin : g_bad_cfg
    $error("cmpt_decoder: illegal compartment configuration");
  end

  logic [NDEC-1:0]         cidx;
  logic [NDEC-1:0]         rel;
  logic [NDEC+LO_SKIP-1:0] full_off;
  logic                    unused_hi;
  logic [RIW-1:0]          ridx;
  logic [NREG-1:0][DW-1:0] regs;
  logic                    rd_q;
  logic [DW-1:0]           rdat_q;

  assign cidx      = bus_addr[LO_SKIP +: NDEC];
  assign unused_hi = ^bus_addr[31:LO_SKIP+NDEC];
  assign sel       = (cidx >= FIRST_V) && (cidx <= LAST_V);
  assign loc_rd    = bus_rd & sel;
  assign loc_wr    = bus_wr & sel;
  assign rel       = cidx - FIRST_V;
  assign full_off  = {rel, bus_addr[LO_SKIP-1:0]};
  assign loc_off   = full_off[OFFW-1:0];
  assign ridx      = loc_off[RIW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (loc_wr) begin
      regs[ridx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      rd_q   <= loc_rd;
      rdat_q <= loc_rd ? regs[ridx] : '0;
    end
  end

  assign rvalid = rd_q;
  assign rdata  = rdat_q;

  p_claimed_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel) |=> rvalid);

  p_no_stray_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && sel) |=> !rvalid);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));

  p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel) |=> $stable(regs));

  p_outside_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!loc_rd && !loc_wr));
endmodule

// File: tb/sim_cmpt_decoder.sv
module sim_cmpt_decoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        sel, loc_rd, loc_wr, rvalid;
  logic [10:0] loc_off;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cmpt_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .sel(sel), .loc_rd(loc_rd),
    .loc_wr(loc_wr), .loc_off(loc_off), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic exp_sel, input logic [10:0] exp_off, input string req);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    bus_wr = 1'b1;
    #1;
    check({req, " sel"}, 32'(sel), 32'(exp_sel));
    check({req, " strobes"}, {30'd0, loc_rd, loc_wr}, exp_sel ? 32'd3 : 32'd0);
    if (exp_sel) check({req, " offset R5"}, 32'(loc_off), 32'(exp_off));
    bus_rd = 1'b0;
    bus_wr = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, input logic exp_v, input logic [31:0] exp_d, input string req);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    #1;
    check({req, " R7 rdata zero before"}, rdata, 32'd0);
    @(negedge clk);
    bus_rd = 1'b0;
    check({req, " R6 rvalid"}, 32'(rvalid), 32'(exp_v));
    check({req, " rdata"}, rdata, exp_d);
    @(negedge clk);
    check({req, " R6 single-cycle valid"}, 32'(rvalid), 32'd0);
    check({req, " R7 rdata zero after"}, rdata, 32'd0);
  endtask

  task automatic t_reset;
    #1;
    check("R9 rvalid in reset", 32'(rvalid), 32'd0);
    check("R9 rdata in reset", rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    do_read(32'h0000_0801, 1'b1, 32'd0, "R9 cleared reg");
  endtask

  task automatic t_edges;
    probe(32'h0000_07FF, 1'b0, 11'h000, "R2 below window");
    probe(32'h0000_0800, 1'b1, 11'h000, "R2 first addr");
    probe(32'h0000_0FFF, 1'b1, 11'h7FF, "R2 last addr");
    probe(32'h0000_1000, 1'b0, 11'h000, "R2 above window");
    probe(32'h0000_0C05, 1'b1, 11'h405, "R3 second compartment");
    probe(32'h0000_0BFF, 1'b1, 11'h3FF, "R3 low bits ignored");
  endtask

  task automatic t_high_bits;
    probe(32'hFFFF_8800, 1'b1, 11'h000, "R1 top bits ignored");
    probe(32'h1234_7800, 1'b0, 11'h000, "R1 slice idx 30");
    probe(32'h0000_8C00, 1'b1, 11'h400, "R1 alias bit15");
  endtask

  task automatic t_regs;
    do_write(32'h0000_0800, 32'hA5A5_0001);
    do_write(32'h0000_0C05, 32'h5A5A_0005);
    do_read(32'h0000_0800, 1'b1, 32'hA5A5_0001, "R8 reg0");
    do_read(32'h0000_0805, 1'b1, 32'h5A5A_0005, "R8 alias reg5");
    do_write(32'h0000_1000, 32'hDEAD_BEEF);
    do_write(32'h0000_07F8, 32'hDEAD_BEEF);
    do_read(32'h0000_0808, 1'b1, 32'hA5A5_0001, "R4 outside write ignored");
    do_read(32'h0000_1000, 1'b0, 32'd0, "R6 outside read");
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_edges;
        t_high_bits;
        t_regs;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule